// File: doc/BRIEF.md
# Alternating Half-Buffer Acquisition Sequencer

This block steers the filling of a shared 4096-word memory that is split into two 2048-word halves. A host raises a start level. On the rising edge the sequencer captures how many blocks the acquisition should contain. It then asks a downstream local-bus burst writer to fill one half after the other: half 0 first, then half 1, then half 0 again, and so on. After the writer reports that a half has been written in full, the sequencer pulses an interrupt line so the host can copy that half away while the other half is being filled.

Once the programmed number of blocks has been written, the sequencer stops and sits idle. It does not start again until the host takes the start level low and then raises it again. The writer interface is a request held until acknowledged, followed later by a one-cycle done strobe. The host start level passes through a short synchronizer. Only a low-to-high change seen after that synchronizer counts as a start.

The controller has five states. IDLE waits for a start edge. REQ presents a burst request. XFER waits for the writer to finish. NOTIFY raises the interrupt for one cycle. HALT parks the block after the last block. The transitions are:
- IDLE to REQ on a start edge with a non-zero total.
- IDLE to HALT on a start edge with a zero total.
- REQ to XFER on acknowledge.
- XFER to NOTIFY on done.
- NOTIFY to REQ when blocks remain.
- NOTIFY to HALT after the final block.
- HALT to IDLE once the synchronized start level is low.

Top module: `pp_acq_seq`

## Requirements
- R1: After reset, wr_req, irq_pulse and busy are 0. A start level that is already high when reset ends does not begin an acquisition.
- R2: A low-to-high change of start_lvl begins an acquisition. While blocks are being run, busy is 1, and the first request appears within a few cycles of the start.
- R3: The base address of block k of an acquisition, counting from 0, is 0 when k is even and 2048 when k is odd. Every acquisition begins at half 0.
- R4: Every request carries a length of 2048 words.
- R5: Once raised, wr_req stays high with an unchanged wr_base until the cycle in which wr_ack is sampled high. In the next cycle wr_req is low.
- R6: Each wr_done while a burst is in flight produces exactly one irq_pulse, one cycle wide, in the cycle right after the done. No irq_pulse occurs at any other time.
- R7: After exactly the number of blocks given by blk_total, no further request is made and busy returns to 0.
- R8: A blk_total of 0 at start runs no blocks and raises no interrupt.
- R9: If start_lvl stays high after completion, no new acquisition starts. A new one needs start_lvl to go low and then high.
- R10: blk_total is captured on the start edge. Changes to it during an acquisition do not change the number of blocks run.
- R11: Taking start_lvl low during an acquisition does not abort it. All programmed blocks still complete.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_lvl | input | 1 | Host start level; a rising change begins an acquisition |
| blk_total | input | CNT_W (16) | Number of blocks to run, captured at start |
| wr_req | output | 1 | Burst request to the writer, held until acknowledged |
| wr_base | output | ADDR_W (12) | Word base address of the half to fill |
| wr_len | output | LEN_W (12) | Burst length in words |
| wr_ack | input | 1 | Writer accepted the request |
| wr_done | input | 1 | Writer finished the current half (one-cycle strobe) |
| irq_pulse | output | 1 | One-cycle interrupt request per completed half |
| busy | output | 1 | Acquisition in progress |

## Verification
The assertions assume the burst writer follows its side of the handshake. It raises wr_ack only while wr_req is high. It raises wr_done once per accepted burst and only after acknowledging it. Under those conditions an interrupt can be tied to a preceding done, and the base address flips between consecutive requests. The bench writer model keeps to this rule. It answers each request after a chosen delay, gives done exactly once per burst, and never drives either strobe outside its window. It sweeps every total from 0 to 5 against short and long acknowledge and done delays.

// File: rtl/pp_acq_pkg.sv
package pp_acq_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_REQ,
        ST_XFER,
        ST_NOTIFY,
        ST_HALT
    } seq_state_e;

endpackage

// File: rtl/pp_start_edge.sv
module pp_start_edge #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic level_i,
    output logic level_o,
    output logic rise_o
);

    logic level_s;
    logic prev_q;

    generate
        if (SYNC_STAGES == 0) begin : g_direct
            assign level_s = level_i;
        end else begin : g_sync
            logic [SYNC_STAGES-1:0] chain_q;
            always_ff @(posedge clk or negedge rst_n) begin
                if (!rst_n) begin
                    chain_q <= '1;
                end else begin
                    chain_q[0] <= level_i;
                    for (int i = 1; i < SYNC_STAGES; i++) begin
                        chain_q[i] <= chain_q[i-1];
                    end
                end
            end
            assign level_s = chain_q[SYNC_STAGES-1];
        end
    endgenerate

    // prev_q resets high, so a level that is already high is not a rise
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prev_q <= 1'b1;
        end else begin
            prev_q <= level_s;
        end
    end

    assign level_o = level_s;
    assign rise_o  = level_s & ~prev_q;

endmodule

// File: rtl/pp_blk_counter.sv
module pp_blk_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_i,
    input  logic [CNT_W-1:0] total_i,
    input  logic             step_i,
    output logic             last_o
);

    logic [CNT_W-1:0] remain_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            remain_q <= '0;
        end else if (load_i) begin
            remain_q <= total_i;
        end else if (step_i && remain_q != '0) begin
            remain_q <= remain_q - CNT_W'(1);
        end
    end

    assign last_o = (remain_q == CNT_W'(1));

endmodule

// File: rtl/pp_half_sel.sv
module pp_half_sel #(
    parameter int BUF_WORDS = 4096,
    parameter int ADDR_W    = $clog2(BUF_WORDS),
    parameter int LEN_W     = $clog2(BUF_WORDS / 2) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clear_i,
    input  logic              flip_i,
    output logic [ADDR_W-1:0] base_o,
    output logic [LEN_W-1:0]  len_o
);

    localparam int HALF_WORDS = BUF_WORDS / 2;

    logic half_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            half_q <= 1'b0;
        end else if (clear_i) begin
            half_q <= 1'b0;
        end else if (flip_i) begin
            half_q <= ~half_q;
        end
    end

    assign base_o = half_q ? ADDR_W'(HALF_WORDS) : '0;
    assign len_o  = LEN_W'(HALF_WORDS);

endmodule

// File: rtl/pp_acq_seq.sv
module pp_acq_seq
    import pp_acq_pkg::*;
#(
    parameter int BUF_WORDS   = 4096,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2,
    parameter int ADDR_W      = $clog2(BUF_WORDS),
    parameter int LEN_W       = $clog2(BUF_WORDS / 2) + 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_lvl,
    input  logic [CNT_W-1:0]  blk_total,
    output logic              wr_req,
    output logic [ADDR_W-1:0] wr_base,
    output logic [LEN_W-1:0]  wr_len,
    input  logic              wr_ack,
    input  logic              wr_done,
    output logic              irq_pulse,
    output logic              busy
);

    seq_state_e state_q, state_d;

    logic lvl_sync;
    logic start_rise;
    logic last_blk;
    logic load_cnt;
    logic step_blk;

    pp_start_edge #(
        .SYNC_STAGES (SYNC_STAGES)
    ) u_edge (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (start_lvl),
        .level_o (lvl_sync),
        .rise_o  (start_rise)
    );

    pp_blk_counter #(
        .CNT_W (CNT_W)
    ) u_cnt (
        .clk     (clk),
        .rst_n   (rst_n),
        .load_i  (load_cnt),
        .total_i (blk_total),
        .step_i  (step_blk),
        .last_o  (last_blk)
    );

    pp_half_sel #(
        .BUF_WORDS (BUF_WORDS),
        .ADDR_W    (ADDR_W),
        .LEN_W     (LEN_W)
    ) u_half (
        .clk     (clk),
        .rst_n   (rst_n),
        .clear_i (load_cnt),
        .flip_i  (step_blk),
        .base_o  (wr_base),
        .len_o   (wr_len)
    );

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start_rise) begin
                    state_d = (blk_total == '0) ? ST_HALT : ST_REQ;
                end
            end
            ST_REQ: begin
                if (wr_ack) state_d = ST_XFER;
            end
            ST_XFER: begin
                if (wr_done) state_d = ST_NOTIFY;
            end
            ST_NOTIFY: begin
                state_d = last_blk ? ST_HALT : ST_REQ;
            end
            ST_HALT: begin
                if (!lvl_sync) state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // outputs
    always_comb begin
        wr_req    = 1'b0;
        irq_pulse = 1'b0;
        busy      = 1'b0;
        load_cnt  = 1'b0;
        step_blk  = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                load_cnt = start_rise;
            end
            ST_REQ: begin
                wr_req = 1'b1;
                busy   = 1'b1;
            end
            ST_XFER: begin
                busy = 1'b1;
            end
            ST_NOTIFY: begin
                irq_pulse = 1'b1;
                busy      = 1'b1;
                step_blk  = 1'b1;
            end
            ST_HALT: begin
            end
            default: begin
            end
        endcase
    end

endmodule

// File: rtl/pp_acq_seq_chk.sv
module pp_acq_seq_chk #(
    parameter int BUF_WORDS = 4096,
    parameter int ADDR_W    = $clog2(BUF_WORDS),
    parameter int LEN_W     = $clog2(BUF_WORDS / 2) + 1
) (
    input logic              clk,
    input logic              rst_n,
    input logic              wr_req,
    input logic [ADDR_W-1:0] wr_base,
    input logic [LEN_W-1:0]  wr_len,
    input logic              wr_ack,
    input logic              wr_done,
    input logic              irq_pulse,
    input logic              busy
);

    localparam int HALF_WORDS = BUF_WORDS / 2;

    a_r3_base_legal: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> (wr_base == '0 || wr_base == ADDR_W'(HALF_WORDS)));

    a_r3_base_flips: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> (!busy || wr_base != $past(wr_base)));

    a_r4_len_fixed: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> wr_len == LEN_W'(HALF_WORDS));

    a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && !wr_ack) |=> (wr_req && $stable(wr_base)));

    a_r5_req_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_req && wr_ack) |=> !wr_req);

    a_r6_irq_single: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |=> !irq_pulse);

    a_r6_irq_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        irq_pulse |-> $past(wr_done));

    a_r7_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (!wr_req && !irq_pulse));

endmodule

bind pp_acq_seq pp_acq_seq_chk #(
    .BUF_WORDS (BUF_WORDS),
    .ADDR_W    (ADDR_W),
    .LEN_W     (LEN_W)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_req    (wr_req),
    .wr_base   (wr_base),
    .wr_len    (wr_len),
    .wr_ack    (wr_ack),
    .wr_done   (wr_done),
    .irq_pulse (irq_pulse),
    .busy      (busy)
);

// File: tb/pp_acq_seq_bench.sv
module pp_acq_seq_bench;

    localparam int BUF_WORDS = 4096;
    localparam int HALF      = BUF_WORDS / 2;
    localparam int CNT_W     = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_lvl = 1'b0;
    logic [15:0] blk_total = '0;
    logic        wr_req;
    logic [11:0] wr_base;
    logic [11:0] wr_len;
    logic        wr_ack = 1'b0;
    logic        wr_done = 1'b0;
    logic        irq_pulse;
    logic        busy;

    int n_chk  = 0;
    int n_fail = 0;
    int irq_seen = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    pp_acq_seq #(.BUF_WORDS(BUF_WORDS), .CNT_W(CNT_W)) u_pp_acq_seq (
        .clk       (clk),
        .rst_n     (rst_n),
        .start_lvl (start_lvl),
        .blk_total (blk_total),
        .wr_req    (wr_req),
        .wr_base   (wr_base),
        .wr_len    (wr_len),
        .wr_ack    (wr_ack),
        .wr_done   (wr_done),
        .irq_pulse (irq_pulse),
        .busy      (busy)
    );

    always_ff @(posedge clk) begin
        if (irq_pulse) irq_seen <= irq_seen + 1;
    end

    task automatic check(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wait_req(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 12; i++) begin
            if (wr_req) begin
                seen = 1'b1;
                break;
            end
            @(negedge clk);
        end
    endtask

    task automatic run_acq(input int total, input int ack_dly, input int done_dly,
                           input bit drop_mid, input bit change_total);
        int irq_start;
        bit seen;
        bit quiet;
        int base0;
        @(negedge clk);
        irq_start = irq_seen;
        blk_total = 16'(total);
        start_lvl = 1'b1;
        @(negedge clk);
        for (int b = 0; b < total; b++) begin
            wait_req(seen);
            check(seen, "R2 request after start", int'(seen), 1);
            if (b == 0) check(busy, "R2 busy during run", int'(busy), 1);
            if (b == 0 && change_total) blk_total = 16'(total + 3); // R10
            check(int'(wr_base) == (b % 2) * HALF, "R3 base address", int'(wr_base), (b % 2) * HALF);
            check(int'(wr_len) == HALF, "R4 burst length", int'(wr_len), HALF);
            base0 = int'(wr_base);
            for (int d = 0; d < ack_dly; d++) begin
                @(negedge clk);
                check(wr_req && int'(wr_base) == base0, "R5 request held", int'(wr_req), 1);
            end
            wr_ack = 1'b1;
            @(negedge clk);
            wr_ack = 1'b0;
            check(!wr_req, "R5 request drops after ack", int'(wr_req), 0);
            for (int d = 0; d < done_dly; d++) begin
                check(!irq_pulse, "R6 no early irq", int'(irq_pulse), 0);
                @(negedge clk);
            end
            wr_done = 1'b1;
            @(negedge clk);
            wr_done = 1'b0;
            check(irq_pulse, "R6 irq after done", int'(irq_pulse), 1);
            if (b == 0 && drop_mid) start_lvl = 1'b0; // R11
            @(negedge clk);
            check(!irq_pulse, "R6 irq one cycle", int'(irq_pulse), 0);
        end
        quiet = 1'b1;
        for (int i = 0; i < 20; i++) begin
            if (wr_req || busy) quiet = 1'b0;
            @(negedge clk);
        end
        if (total == 0) check(quiet, "R8 zero total runs nothing", int'(quiet), 1);
        else            check(quiet, "R7 R9 stop after last block", int'(quiet), 1);
        check(irq_seen - irq_start == total, "R6 R10 R11 interrupt count",
              irq_seen - irq_start, total);
        start_lvl = 1'b0;
        repeat (5) @(negedge clk);
    endtask

    initial begin
        bit quiet;
        start_lvl = 1'b1; // R1: high through reset
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check(!wr_req && !irq_pulse && !busy, "R1 reset outputs", int'({wr_req, irq_pulse, busy}), 0);
        quiet = 1'b1;
        for (int i = 0; i < 15; i++) begin
            @(negedge clk);
            if (wr_req || busy) quiet = 1'b0;
        end
        check(quiet, "R1 level high at reset is no start", int'(quiet), 1);
        start_lvl = 1'b0;
        repeat (5) @(negedge clk);

        for (int t = 0; t <= 5; t++) begin
            for (int a = 0; a < 2; a++) begin
                for (int d = 0; d < 2; d++) begin
                    run_acq(t, a * 2, d * 3, 1'b0, 1'b0);
                end
            end
        end
        run_acq(3, 1, 1, 1'b0, 1'b1); // R10
        run_acq(3, 1, 1, 1'b1, 1'b0); // R11
        run_acq(1, 0, 0, 1'b0, 1'b0); // R3 restart at half 0

        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            n_fail++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

endmodule